// File: doc/BRIEF.md
# Reload-Offset PWM Timer

This block is a wide up-counter that generates a pulse-width modulated output. The counter counts up one step per count enable. Past its all-ones value it wraps to a programmable reload value instead of zero. The wrap event drives the waveform to its active level. The count step taken from the programmed match value drives it back to the inactive level. The period is therefore set by how far the reload value sits below the top of the count range, and the active time is set by how far the match value sits above the reload value.

Software drives the block through a plain write strobe and a combinational read port with four word addresses: reload, match, counter and control/status. The control word starts and stops the timer, selects an inverted output and configures a power-of-two count-enable divider. Stopping is abrupt: the counter freezes where it is and the output goes inactive. Before a start, software normally seeds the counter with all-ones minus one. A polarity change requested while running makes the hardware stop, switch polarity, reseed the counter and start a fresh cycle. Reload and match writes take effect at once with no shadow copy, so one period around an update may mix old and new settings.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset, reload, match and counter read 0. The status word reads 0 (stopped, normal polarity, divider off). `pwm_o` is 0.
- R2: While running, the counter rises by one on each count enable. On the count enable taken at all-ones it loads the reload value.
- R3: The count enable taken at all-ones makes the waveform active. The count enable taken at the match value makes it inactive. The active time is match − reload + 1 count enables, the inactive time is all-ones − match, and the period is all-ones − reload + 1 (for reload ≤ match < all-ones).
- R4: Writing the control word with run bit (bit 0) = 0 while running freezes the counter on that edge and makes the waveform inactive on the following cycle.
- R5: Control bit 1 (invert) makes `pwm_o` the complement of the waveform, including while stopped (stopped and inverted gives `pwm_o` = 1).
- R6: A control write with run = 1 whose invert bit differs from the current one, made while running, reseeds the counter to all-ones minus one. The waveform becomes inactive, the new polarity applies, and the timer keeps running.
- R7: A counter write (address 2) loads the counter while stopped and is ignored while running.
- R8: Reload (address 0) and match (address 1) writes take effect on the next count with no shadow stage, so later periods follow the new values.
- R9: With control bit 2 = 0 the counter advances every clock. With bit 2 = 1 and the 3-bit field P in bits 5:3, it advances once every 2^(P+1) clocks.
- R10: Reading address 3 returns the control state: bit 0 running, bit 1 invert, bit 2 divider enable, bits 5:3 P, all other bits 0.
- R11: A stop written on the same edge as an overflow count enable wins. The counter stays at all-ones and the waveform stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 reload, 1 match, 2 counter, 3 control |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 reload, 1 match, 2 counter, 3 status |
| rd_data | output | 32 | Combinational read data |
| pwm_o | output | 1 | PWM output after polarity |

## Verification
Two events can fall on the same edge: a stop write from software and the overflow count enable that would raise the waveform. The bench seeds the counter to all-ones minus one, starts the timer, and times the stop write to land exactly two edges later, on the edge where the wrap would occur. It then judges the outcome at the ports. The counter must read all-ones rather than the reload value, and the output must be inactive. A second collision places a polarity-change restart on a running edge; the counter must read the seed value, not an advanced count.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;

    localparam int CNT_W = 32;
    localparam int PSC_W = 3;

    typedef enum logic [1:0] {
        A_RELOAD = 2'd0,
        A_MATCH  = 2'd1,
        A_COUNT  = 2'd2,
        A_CTRL   = 2'd3
    } reg_addr_e;

    // Control word: bit 0 run, bit 1 invert, bit 2 divider enable, bits 5:3 divider exponent
    typedef struct packed {
        logic [PSC_W-1:0] psc_val;
        logic             psc_en;
        logic             invert;
        logic             run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic ctrl_t decode_ctrl(input logic [CNT_W-1:0] d);
        return ctrl_t'(d[CTRL_W-1:0]);
    endfunction

    function automatic logic [CNT_W-1:0] seed_value();
        return {{(CNT_W-1){1'b1}}, 1'b0};
    endfunction

endpackage

// File: rtl/rpwm_regs.sv
module rpwm_regs
    import rpwm_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] reload_q,
    output logic [W-1:0] match_q,
    output ctrl_t        ctrl_q,
    output logic         cnt_wr,
    output logic         restart,
    output logic         stop_now
);

    ctrl_t new_ctrl;
    logic  ctrl_wr;

    always_comb begin
        new_ctrl = decode_ctrl(wr_data);
        ctrl_wr  = wr_en && (wr_addr == A_CTRL);
        stop_now = ctrl_wr && ctrl_q.run && !new_ctrl.run;
        restart  = ctrl_wr && ctrl_q.run && new_ctrl.run &&
                   (new_ctrl.invert != ctrl_q.invert);
        cnt_wr   = wr_en && (wr_addr == A_COUNT) && !ctrl_q.run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            match_q  <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_RELOAD: reload_q <= wr_data;
                A_MATCH:  match_q  <= wr_data;
                A_CTRL:   ctrl_q   <= new_ctrl;
                default:  ;
            endcase
        end
    end

    // R4: a stop request leaves the block stopped
    a_r4_stop_clears_run: assert property (@(posedge clk) disable iff (rst)
        stop_now |=> !ctrl_q.run);

    // R6: a polarity restart keeps the timer running
    a_r6_restart_runs: assert property (@(posedge clk) disable iff (rst)
        restart |=> (ctrl_q.run && ($past(ctrl_q.invert) != ctrl_q.invert)));

endmodule

// File: rtl/rpwm_prescale.sv
module rpwm_prescale
    import rpwm_pkg::*;
#(
    parameter int PW      = PSC_W,
    parameter bit HAS_PSC = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clr,
    input  logic          en,
    input  logic [PW-1:0] val,
    output logic          tick
);

    localparam int DIV_W = 1 << PW;

    generate
        if (HAS_PSC) begin : g_div
            logic [DIV_W-1:0] div_q;
            logic [DIV_W-1:0] mask;

            always_comb begin
                for (int i = 0; i < DIV_W; i++) begin
                    mask[i] = (i <= int'(val));
                end
                tick = run && (!en || (div_q == mask));
            end

            always_ff @(posedge clk) begin
                if (rst || clr || !en || !run) begin
                    div_q <= '0;
                end else if (tick) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            // R9: with the divider on, two count enables are never adjacent
            a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
                (tick && en) |=> !tick);
        end else begin : g_bypass
            assign tick = run;
        end
    endgenerate

endmodule

// File: rtl/rpwm_core.sv
module rpwm_core
    import rpwm_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         stop_now,
    input  logic         restart,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] reload_i,
    input  logic [W-1:0] match_i,
    output logic [W-1:0] cnt_q,
    output logic         lvl_q
);

    localparam logic [W-1:0] TOP  = '1;
    localparam logic [W-1:0] SEED = seed_value();

    logic at_top;
    logic at_match;

    assign at_top   = (cnt_q == TOP);
    assign at_match = (cnt_q == match_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (stop_now) begin
            lvl_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= SEED;
            lvl_q <= 1'b0;
        end else if (cnt_wr) begin
            cnt_q <= wr_data;
        end else if (tick) begin
            if (at_top) begin
                cnt_q <= reload_i;
                lvl_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (at_match) lvl_q <= 1'b0;
            end
        end
    end

    // R2: wrap loads the reload value
    a_r2_wrap_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && (cnt_q == TOP) && !stop_now && !restart) |=> (cnt_q == $past(reload_i)));

    // R3: overflow raises the waveform
    a_r3_overflow_active: assert property (@(posedge clk) disable iff (rst)
        (tick && (cnt_q == TOP) && !stop_now && !restart) |=> lvl_q);

    // R3: match lowers the waveform
    a_r3_match_inactive: assert property (@(posedge clk) disable iff (rst)
        (tick && (cnt_q == match_i) && (cnt_q != TOP) && !stop_now && !restart) |=> !lvl_q);

    // R4: stop freezes the counter and drops the waveform
    a_r4_freeze: assert property (@(posedge clk) disable iff (rst)
        stop_now |=> (!lvl_q && $stable(cnt_q)));

    // R6: restart reseeds the counter
    a_r6_reseed: assert property (@(posedge clk) disable iff (rst)
        (restart && !stop_now) |=> (cnt_q == SEED && !lvl_q));

endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer
    import rpwm_pkg::*;
#(
    parameter int W       = CNT_W,
    parameter bit HAS_PSC = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    output logic         pwm_o
);

    logic [W-1:0] reload_q;
    logic [W-1:0] match_q;
    logic [W-1:0] cnt_q;
    ctrl_t        ctrl_q;
    logic         cnt_wr;
    logic         restart;
    logic         stop_now;
    logic         tick;
    logic         lvl_q;

    rpwm_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .reload_q (reload_q),
        .match_q  (match_q),
        .ctrl_q   (ctrl_q),
        .cnt_wr   (cnt_wr),
        .restart  (restart),
        .stop_now (stop_now)
    );

    rpwm_prescale #(.PW(PSC_W), .HAS_PSC(HAS_PSC)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .clr  (restart),
        .en   (ctrl_q.psc_en),
        .val  (ctrl_q.psc_val),
        .tick (tick)
    );

    rpwm_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .stop_now (stop_now),
        .restart  (restart),
        .cnt_wr   (cnt_wr),
        .wr_data  (wr_data),
        .reload_i (reload_q),
        .match_i  (match_q),
        .cnt_q    (cnt_q),
        .lvl_q    (lvl_q)
    );

    always_comb begin
        case (rd_addr)
            A_RELOAD: rd_data = reload_q;
            A_MATCH:  rd_data = match_q;
            A_COUNT:  rd_data = cnt_q;
            default:  rd_data = {{(W-CTRL_W){1'b0}}, ctrl_q};
        endcase
    end

    assign pwm_o = lvl_q ^ ctrl_q.invert;

    // R5: stopped output follows the invert bit only
    a_r5_stopped_level: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run |-> (pwm_o == ctrl_q.invert));

endmodule

// File: tb/tb_reload_pwm_timer.sv
module tb_reload_pwm_timer;

    localparam logic [31:0] TOP  = 32'hFFFF_FFFF;
    localparam logic [31:0] SEED = 32'hFFFF_FFFE;
    localparam int NROW = 5;
    localparam int P_T [NROW] = '{2, 4, 5, 7, 3};
    localparam int D_T [NROW] = '{1, 2, 4, 1, 2};
    localparam int E_T [NROW] = '{0, 0, 0, 1, 1};
    localparam int V_T [NROW] = '{0, 0, 0, 0, 1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pwm_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    reload_pwm_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctrl(input int run, input int inv, input int en, input int v);
        return 32'((v << 3) | (en << 2) | (inv << 1) | run);
    endfunction

    task automatic wait_rise(output bit ok);
        logic prev;
        ok = 1'b0;
        prev = pwm_o;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!prev && pwm_o) begin ok = 1'b1; break; end
            prev = pwm_o;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        bit ok;
        hi = 0; lo = 0;
        wait_rise(ok);
        if (ok) wait_rise(ok);
        if (!ok) return;
        while (pwm_o && hi < 4000) begin hi++; @(negedge clk); end
        while (!pwm_o && lo < 4000) begin lo++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int hi, lo, div;
        logic [31:0] c1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd_addr = 2'd0; #1 check("R1 reload", rd_data, 32'd0);
        rd_addr = 2'd1; #1 check("R1 match", rd_data, 32'd0);
        rd_addr = 2'd2; #1 check("R1 count", rd_data, 32'd0);
        rd_addr = 2'd3; #1 check("R1 status", rd_data, 32'd0);
        check("R1 pwm_o", {31'd0, pwm_o}, 32'd0);

        // R7: counter write while stopped
        wr(2'd2, SEED);
        rd_addr = 2'd2; #1 check("R7 stopped write", rd_data, SEED);

        // Table walk: R2 R3 R8 R9 (settings rewritten while running)
        for (int r = 0; r < NROW; r++) begin
            logic [31:0] ld;
            ld = TOP - 32'(P_T[r]) + 32'd1;
            wr(2'd0, ld);
            wr(2'd1, ld + 32'(D_T[r]) - 32'd1);
            wr(2'd3, ctrl(1, 0, E_T[r], V_T[r]));
            div = (E_T[r] != 0) ? (1 << (V_T[r] + 1)) : 1;
            measure(hi, lo);
            check($sformatf("R3 R8 R9 active row%0d", r), 32'(hi), 32'(D_T[r] * div));
            check($sformatf("R2 R3 R9 inactive row%0d", r), 32'(lo), 32'((P_T[r] - D_T[r]) * div));
        end

        // R10: status reflects last control write (run, en=1, P=1)
        rd_addr = 2'd3; #1 check("R10 status", rd_data, 32'h0000_000D);

        // R7: counter write ignored while running (reload = TOP-2)
        wr(2'd2, 32'h0000_1234);
        rd_addr = 2'd2; #1
        check("R7 running write ignored", {31'd0, (rd_data >= 32'hFFFF_FFFD)}, 32'd1);

        // R4: stop freezes counter and output
        wr(2'd3, ctrl(0, 0, 0, 0));
        rd_addr = 2'd2; #1 c1 = rd_data;
        repeat (5) @(negedge clk);
        check("R4 counter frozen", rd_data, c1);
        check("R4 output inactive", {31'd0, pwm_o}, 32'd0);

        // R5: inverted while stopped
        wr(2'd3, ctrl(0, 1, 0, 0));
        check("R5 stopped inverted", {31'd0, pwm_o}, 32'd1);

        // R6: polarity change while running restarts
        wr(2'd2, SEED);
        wr(2'd3, ctrl(1, 1, 0, 0));
        repeat (7) @(negedge clk);
        rd_addr = 2'd2;
        wr(2'd3, ctrl(1, 0, 0, 0));
        check("R6 reseeded", rd_data, SEED);
        check("R6 output inactive", {31'd0, pwm_o}, 32'd0);
        rd_addr = 2'd3; #1 check("R6 still running", rd_data, 32'h0000_0001);

        // R11: stop on the overflow edge wins
        wr(2'd3, ctrl(0, 0, 0, 0));
        wr(2'd2, SEED);
        wr(2'd3, ctrl(1, 0, 0, 0));
        wr(2'd3, ctrl(0, 0, 0, 0));
        rd_addr = 2'd2; #1
        check("R11 counter at top", rd_data, TOP);
        check("R11 output inactive", {31'd0, pwm_o}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule